// File: doc/BRIEF.md
# External interrupt request controller

This block merges two kinds of external interrupt source into one request for the CPU: a dedicated active-low interrupt pin and a group of active-high port inputs. The two sides lock each other out. Once one side has raised the combined request, activity on the other side is not seen until the owning side has fully gone idle: all port inputs low, or the pin back high. A separate configuration input decides whether the port inputs act as interrupt sources at all. Every pin passes through a two-flop synchronizer before it is used.

A rising edge of the combined request sets a pending flag. The flag sits in an 8-bit status/control register that the CPU reads and writes at a fixed bus address. That register also holds an interrupt enable bit, a write-only bit that clears the flag, and two oscillator-select bits. The oscillator-select bits are plain storage and are driven straight out to the clock logic. The request to the CPU is the flag gated by the enable bit. The flag keeps latching events while the enable bit is 0, so an event that arrives while interrupts are masked is delivered as soon as they are unmasked.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register at address 0x0D reads 0xC0, `irq_req` is 0 and `osc_sel` is 2'b10.
- R2: The register at 0x0D reads as follows: bit 7 is the enable, bit 6 is oscillator select 2, bit 5 is oscillator select 1, and bit 3 is the pending flag. Bits 4, 2, 1 and 0 always read 0. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R3: With `port_irq_en`=1, a high level on any port input raises the combined request. While any port input stays high, a low level on the pin and new high levels on other port inputs raise no new event.
- R4: A low level on the pin raises the combined request. While the pin stays low, the port inputs raise no new event.
- R5: A rising edge of the combined request sets the flag. The flag reads 1 on the fourth rising clock edge after the pin input changes: two synchronizer stages, one arbitration stage and the flag itself. It then holds until it is cleared, even after the source returns to idle.
- R6: A write to 0x0D with bit 1 = 1 clears the flag at that clock edge. If an event sets the flag at the same edge, the set wins.
- R7: `irq_req` equals the flag AND the enable bit (bit 7). The flag still latches events while the enable bit is 0.
- R8: With `port_irq_en`=0 the port inputs have no effect, and only the pin can raise an event.
- R9: `osc_sel` equals {bit 6, bit 5} of the register, and a write to 0x0D loads bits 7, 6 and 5 from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_irq_n | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_in | input | 4 | Port interrupt inputs, active high, asynchronous |
| port_irq_en | input | 1 | Enables the port inputs as interrupt sources |
| bus_addr | input | 8 | CPU bus address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_req | output | 1 | Interrupt request to the CPU |
| osc_sel | output | 2 | Oscillator select bits {select 2, select 1} |

## Verification
The assertions assume that the pin and port inputs are already synchronized where they are checked. They also assume that `port_irq_en` is static configuration and only changes while both source sides are idle. The bench changes `port_irq_en` only in steps where the arbiter has no owner. It holds each input pattern for six cycles, which is longer than the four-stage path, and it drives bus strobes one cycle wide on the falling edge. The set-versus-clear race is produced on purpose by counting the exact edge at which the flag rises.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int REG_W    = 8;
   localparam int BIT_EN   = 7;
   localparam int BIT_OSC2 = 6;
   localparam int BIT_OSC1 = 5;
   localparam int BIT_FLAG = 3;
   localparam int BIT_CLR  = 1;
   localparam logic [REG_W-1:0] REG_RESET = 8'hC0;

   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_PIN  = 2'd1,
      OWN_PORT = 2'd2
   } owner_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int               WIDTH    = 1,
   parameter int               STAGES   = 2,
   parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ext_irq_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ext_irq_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
   import ext_irq_pkg::*;
#(
   parameter int NUM_PORT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin_n_s,
   input  logic [NUM_PORT-1:0] port_s,
   input  logic                port_en,
   output logic                req_rise
);
   logic   port_any;
   logic   pin_act;
   logic   req_q;
   owner_e owner_q, owner_d;

   generate
      if (NUM_PORT == 1) begin : g_one_port
         assign port_any = port_en & port_s[0];
      end else begin : g_many_ports
         assign port_any = port_en & (|port_s);
      end
   endgenerate

   assign pin_act = ~pin_n_s;

   always_comb begin
      owner_d = owner_q;
      case (owner_q)
         OWN_IDLE: begin
            if (port_any)     owner_d = OWN_PORT;
            else if (pin_act) owner_d = OWN_PIN;
         end
         OWN_PORT: if (!port_any) owner_d = OWN_IDLE;
         OWN_PIN:  if (!pin_act)  owner_d = OWN_IDLE;
         default:  owner_d = OWN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_IDLE;
         req_q   <= 1'b0;
      end else begin
         owner_q <= owner_d;
         req_q   <= (owner_q != OWN_IDLE);
      end
   end

   assign req_rise = (owner_q != OWN_IDLE) && !req_q;

   assert_port_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_PORT && port_any) |=> (owner_q == OWN_PORT && !req_rise));
   assert_pin_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q == OWN_PIN && pin_act) |=> (owner_q == OWN_PIN && !req_rise));
   assert_ports_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_en && owner_q == OWN_IDLE && !pin_act) |=> (owner_q == OWN_IDLE));
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
#(
   parameter int               ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              req_rise,
   output logic              irq_req,
   output logic [1:0]        osc_sel
);
   logic hit, wr_hit, clr_req;
   logic en_q, osc2_q, osc1_q, flag_q;
   logic unused_wbits;

   assign hit     = (bus_addr == REG_ADDR);
   assign wr_hit  = hit && bus_wr;
   assign clr_req = wr_hit && bus_wdata[BIT_CLR];
   assign unused_wbits = ^{bus_wdata[4], bus_wdata[3], bus_wdata[2], bus_wdata[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= REG_RESET[BIT_EN];
         osc2_q <= REG_RESET[BIT_OSC2];
         osc1_q <= REG_RESET[BIT_OSC1];
         flag_q <= REG_RESET[BIT_FLAG];
      end else begin
         if (wr_hit) begin
            en_q   <= bus_wdata[BIT_EN];
            osc2_q <= bus_wdata[BIT_OSC2];
            osc1_q <= bus_wdata[BIT_OSC1];
         end
         if (req_rise)     flag_q <= 1'b1;
         else if (clr_req) flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata[BIT_EN]   = en_q;
         bus_rdata[BIT_OSC2] = osc2_q;
         bus_rdata[BIT_OSC1] = osc1_q;
         bus_rdata[BIT_FLAG] = flag_q;
      end
   end

   assign irq_req = flag_q & en_q;
   assign osc_sel = {osc2_q, osc1_q};

   assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_rise |=> flag_q);
   assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_req) |=> flag_q);
   assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !req_rise) |=> !flag_q);
   assert_osc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (osc_sel == $past(bus_wdata[BIT_OSC2:BIT_OSC1])));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int               NUM_PORT    = 4,
   parameter int               SYNC_STAGES = 2,
   parameter int               ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h0D
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin_irq_n,
   input  logic [NUM_PORT-1:0] port_in,
   input  logic                port_irq_en,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   output logic                irq_req,
   output logic [1:0]          osc_sel
);
   generate
      if (NUM_PORT < 1 || NUM_PORT > REG_W) begin : g_bad_ports
         $error("ext_irq_ctrl: NUM_PORT out of range");
      end
   endgenerate

   logic                pin_n_s;
   logic [NUM_PORT-1:0] port_s;
   logic                req_rise;

   ext_irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_irq_n), .q(pin_n_s));

   ext_irq_sync #(.WIDTH(NUM_PORT), .STAGES(SYNC_STAGES), .IDLE_VAL('0)) u_port_sync (
      .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s));

   ext_irq_arb #(.NUM_PORT(NUM_PORT)) u_arb (
      .clk(clk), .rst_n(rst_n), .pin_n_s(pin_n_s), .port_s(port_s),
      .port_en(port_irq_en), .req_rise(req_rise));

   ext_irq_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_rise(req_rise),
      .irq_req(irq_req), .osc_sel(osc_sel));
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_irq_n = 1'b1;
   logic [3:0] port_in = 4'h0;
   logic       port_irq_en = 1'b1;
   logic [7:0] bus_addr = 8'h0D;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_req;
   logic [1:0] osc_sel;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ext_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pin_irq_n(pin_irq_n), .port_in(port_in),
      .port_irq_en(port_irq_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
      .osc_sel(osc_sel));

   // fields: {pin_n, port[3:0], port_en, expected read of 0x0D}
   localparam int NV = 15;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 4'b0000, 1'b1, 8'hC0},  // idle
      {1'b1, 4'b0001, 1'b1, 8'hC8},  // R3 port event
      {1'b0, 4'b0001, 1'b1, 8'hC0},  // R3 pin ignored
      {1'b0, 4'b0011, 1'b1, 8'hC0},  // R3 more ports ignored
      {1'b1, 4'b0010, 1'b1, 8'hC0},  // R3 still owned by ports
      {1'b1, 4'b0000, 1'b1, 8'hC0},  // release
      {1'b0, 4'b0000, 1'b1, 8'hC8},  // R4 pin event
      {1'b0, 4'b0100, 1'b1, 8'hC0},  // R4 port ignored
      {1'b0, 4'b0000, 1'b1, 8'hC0},
      {1'b1, 4'b0000, 1'b1, 8'hC0},  // release
      {1'b1, 4'b1000, 1'b0, 8'hC0},  // R8 port off
      {1'b0, 4'b1000, 1'b0, 8'hC8},  // R8 pin still works
      {1'b1, 4'b0000, 1'b0, 8'hC0},
      {1'b1, 4'b1111, 1'b1, 8'hC8},  // R3 all ports at once
      {1'b1, 4'b0000, 1'b1, 8'hC0}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 8'h0D;
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
      bus_addr = 8'h0D;
   endtask

   task automatic summary;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         summary();
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd_chk("R1 reset register", 8'h0D, 8'hC0);
      chk("R1 reset irq_req", {7'd0, irq_req}, 8'h00);
      chk("R1 reset osc_sel", {6'd0, osc_sel}, 8'h02);

      // table walk: lockout R3 R4 R8, flag R5
      for (int i = 0; i < NV; i++) begin
         wr(8'h0D, 8'hC2);
         pin_irq_n   = VEC[i][13];
         port_in     = VEC[i][12:9];
         port_irq_en = VEC[i][8];
         tick(6);
         rd_chk($sformatf("R3 R4 R8 vector %0d", i), 8'h0D, VEC[i][7:0]);
         chk($sformatf("R7 vector %0d irq_req", i), {7'd0, irq_req}, {7'd0, VEC[i][3]});
      end

      // R5 latency and hold
      wr(8'h0D, 8'hC2);
      pin_irq_n = 1'b0;
      tick(3);
      rd_chk("R5 flag not yet set after 3 edges", 8'h0D, 8'hC0);
      tick(1);
      rd_chk("R5 flag set on 4th edge", 8'h0D, 8'hC8);
      chk("R7 irq_req with enable", {7'd0, irq_req}, 8'h01);
      pin_irq_n = 1'b1;
      tick(6);
      rd_chk("R5 flag holds after source idle", 8'h0D, 8'hC8);
      wr(8'h0D, 8'hC2);
      rd_chk("R6 clear", 8'h0D, 8'hC0);

      // R6 set wins over clear at the same edge
      pin_irq_n = 1'b0;
      tick(3);
      wr(8'h0D, 8'hC2);
      rd_chk("R6 set wins over clear", 8'h0D, 8'hC8);
      pin_irq_n = 1'b1;
      tick(6);
      wr(8'h0D, 8'hC2);
      rd_chk("R6 clear after race", 8'h0D, 8'hC0);

      // R7 flag latches while disabled
      wr(8'h0D, 8'h42);
      rd_chk("R7 enable off", 8'h0D, 8'h40);
      pin_irq_n = 1'b0;
      tick(6);
      rd_chk("R7 flag latched while disabled", 8'h0D, 8'h48);
      chk("R7 irq_req masked", {7'd0, irq_req}, 8'h00);
      wr(8'h0D, 8'hC0);
      chk("R7 irq_req after enable", {7'd0, irq_req}, 8'h01);
      pin_irq_n = 1'b1;
      tick(6);
      wr(8'h0D, 8'hC2);

      // R9 oscillator selects, R2 unimplemented bits
      wr(8'h0D, 8'hA0);
      rd_chk("R9 read after A0", 8'h0D, 8'hA0);
      chk("R9 osc_sel 01", {6'd0, osc_sel}, 8'h01);
      wr(8'h0D, 8'hFF);
      rd_chk("R2 unimplemented and clear bits read 0", 8'h0D, 8'hE0);
      chk("R9 osc_sel 11", {6'd0, osc_sel}, 8'h03);
      wr(8'h0D, 8'hC0);

      // R2 other addresses
      rd_chk("R2 other address reads 0", 8'h0C, 8'h00);
      wr(8'h0E, 8'h00);
      rd_chk("R2 write elsewhere ignored", 8'h0D, 8'hC0);
      chk("R2 osc_sel unchanged", {6'd0, osc_sel}, 8'h02);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule